// File: doc/BRIEF.md
# I2C Target Read-Transfer Status Engine

This block is an I2C target that serves read transfers only. It watches the resolved SCL and SDA lines, recognises START and STOP conditions, and collects the address byte. If the seven address bits equal its own address and the direction bit asks for a read, it acknowledges. It then shifts out bytes that the host places on its data input. Each step of the transfer ends with an interrupt flag and an 8-bit status code. The block keeps SCL low until the host clears the flag, and the host answers by loading the next byte and choosing whether that byte is the last.

A START or STOP that arrives in the middle of an address byte, a data byte or an acknowledge bit is reported as a bus error with a separate status code. Only a clear that also carries the stop request leaves that state. The block models open-drain pads: it reports when it wants each line pulled low, and it never drives a line high. An external master may mark that it has just lost arbitration, and the next matching read address is then reported with a different code.

Top module: `i2c_tgt_tx_status`

## Requirements
- R1: After reset the flag `si_o` is 0, `status_o` is 0xF8, and neither `scl_oe_o` nor `sda_oe_o` is asserted.
- R2: Whenever `si_o` is 0, `status_o` reads 0xF8.
- R3: After a START, an address byte whose upper seven bits (sent MSB first) equal `own_addr_i` and whose eighth bit is 1 is acknowledged: SDA is held low during the ninth clock. After that clock falls, `si_o` rises with status 0xA8.
- R4: An address byte with a different address, or with its eighth bit 0, is not acknowledged (SDA stays high on the ninth clock), and `si_o` stays 0.
- R5: If `arb_lost_i` was pulsed before a matching read address byte completes, that byte is reported with status 0xB0 instead of 0xA8.
- R6: A host write with `host_wr_i` and `host_si_clr_i` at 1, made after status 0xA8, 0xB0 or 0xB8, takes `tx_data_i` as the next byte. The byte is sent MSB first, and `sda_oe_o` changes only while SCL is low.
- R7: If `aa_i` was 1 at that clear and the master acknowledges the byte (SDA low on the ninth clock), status 0xB8 follows.
- R8: If the master does not acknowledge a byte, status 0xC0 follows. After that clear the block is not addressed: further clocks read all ones and raise no flag.
- R9: If `aa_i` was 0 at the clear, the byte is the last one. An acknowledge from the master gives status 0xC8, and after that clear later clocks read all ones.
- R10: While `si_o` is 1, `scl_oe_o` holds SCL low. The clear write releases it.
- R11: A START or STOP during an address byte (after its first bit), a data byte or an acknowledge bit sets `si_o` with status 0x00. This takes precedence over the acknowledge status for that byte.
- R12: In the bus-error state a clear without `host_sto_i` has no effect. A clear with `host_sto_i` at 1 drops `si_o`, restores status 0xF8, and leaves both lines released, so no STOP is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Resolved SCL line level |
| sda_i | input | 1 | Resolved SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| own_addr_i | input | 7 | Own target address |
| tx_data_i | input | 8 | Next byte to transmit, taken at the clear write |
| aa_i | input | 1 | 1 means more bytes follow the next one; sampled at the clear write |
| host_wr_i | input | 1 | Host control write strobe |
| host_si_clr_i | input | 1 | With the strobe: clear the interrupt flag |
| host_sto_i | input | 1 | With the strobe: stop request (leaves the bus-error state) |
| arb_lost_i | input | 1 | Pulse: an own master attempt just lost arbitration |
| si_o | output | 1 | Interrupt flag |
| status_o | output | 8 | Status code |

## Verification
Two decisions can land in the same step. On the ninth clock, the acknowledge bit taken at the rising edge competes with a START seen while SCL is still high. The bench provokes this by letting SDA float for a not-acknowledge and then pulling it low before SCL falls, and it requires 0x00 rather than 0xC0. Likewise, the clear write is the single cycle in which the data byte is loaded, its first bit is driven and `aa_i` is captured. The bench varies `aa_i` and `tx_data_i` only at that write and judges the received bytes and the 0xB8/0xC8 outcome against a queue of expected status codes, compared on every rise of the flag.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam logic [7:0] CODE_NONE     = 8'hF8;
  localparam logic [7:0] CODE_BUSERR   = 8'h00;
  localparam logic [7:0] CODE_ADDR_RD  = 8'hA8;
  localparam logic [7:0] CODE_ARB_RD   = 8'hB0;
  localparam logic [7:0] CODE_DATA_ACK = 8'hB8;
  localparam logic [7:0] CODE_DATA_NAK = 8'hC0;
  localparam logic [7:0] CODE_LAST_ACK = 8'hC8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_TX,
    S_TACK,
    S_HOLD,
    S_ERR
  } tgt_state_e;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
    logic sda_lvl;
    logic scl_lvl;
  } bus_ev_t;

endpackage

// File: rtl/i2c_tgt_line_mon.sv
module i2c_tgt_line_mon
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);

  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic [SYNC_STAGES:0]   scl_cat, sda_cat;
  logic                   scl_p, sda_p, scl_s, sda_s;

  assign scl_cat = {scl_ff, scl_i};
  assign sda_cat = {sda_ff, sda_i};
  assign scl_s   = scl_ff[SYNC_STAGES-1];
  assign sda_s   = sda_ff[SYNC_STAGES-1];

  // idle bus is high on both lines
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= scl_cat[SYNC_STAGES-1:0];
      sda_ff <= sda_cat[SYNC_STAGES-1:0];
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  always_comb begin
    ev_o.scl_rise = scl_s & ~scl_p;
    ev_o.scl_fall = ~scl_s & scl_p;
    ev_o.start    = scl_s & scl_p & sda_p & ~sda_s;
    ev_o.stop     = scl_s & scl_p & ~sda_p & sda_s;
    ev_o.sda_lvl  = sda_s;
    ev_o.scl_lvl  = scl_s;
  end

endmodule

// File: rtl/i2c_tgt_byte_shift.sv
module i2c_tgt_byte_shift #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [W-1:0]  load_val_i,
  input  logic          rx_i,
  input  logic          tx_i,
  input  logic          bit_i,
  input  logic          cnt_clr_i,
  input  logic          cnt_inc_i,
  output logic [W-1:0]  sr_o,
  output logic [CW-1:0] cnt_o
);

  logic [W-1:0]  sr_d;
  logic [CW-1:0] cnt_d;

  always_comb begin
    sr_d = sr_o;
    if (load_i)      sr_d = load_val_i;
    else if (rx_i)   sr_d = {sr_o[W-2:0], bit_i};
    else if (tx_i)   sr_d = {sr_o[W-2:0], 1'b1};
    cnt_d = cnt_o;
    if (cnt_clr_i)      cnt_d = '0;
    else if (cnt_inc_i) cnt_d = cnt_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_o  <= '1;
      cnt_o <= '0;
    end else begin
      if (load_i || rx_i || tx_i)   sr_o  <= sr_d;
      if (cnt_clr_i || cnt_inc_i)   cnt_o <= cnt_d;
    end
  end

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bus_ev_t       ev_i,
  input  logic [W-1:0]  sr_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [W-2:0]  own_addr_i,
  input  logic          tx_msb_i,
  input  logic          aa_i,
  input  logic          host_wr_i,
  input  logic          host_si_clr_i,
  input  logic          host_sto_i,
  input  logic          arb_lost_i,
  output logic          load_o,
  output logic          rx_o,
  output logic          tx_o,
  output logic          cnt_clr_o,
  output logic          cnt_inc_o,
  output logic          si_o,
  output logic [7:0]    status_o,
  output logic          sda_oe_o
);

  localparam logic [CW-1:0] FULL = CW'(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  tgt_state_e st_q, st_d;
  logic       si_d, sda_d, last_q, last_d, ack_q, ack_d, arb_q, arb_d;
  logic [7:0] status_d;
  logic       bus_evt, addr_hit, clr_req;

  assign bus_evt  = ev_i.start | ev_i.stop;
  assign addr_hit = (sr_i[W-1:1] == own_addr_i) & sr_i[0];
  assign clr_req  = host_wr_i & host_si_clr_i;

  always_comb begin
    st_d      = st_q;
    si_d      = si_o;
    status_d  = status_o;
    sda_d     = sda_oe_o;
    last_d    = last_q;
    ack_d     = ack_q;
    arb_d     = arb_q | arb_lost_i;
    load_o    = 1'b0;
    rx_o      = 1'b0;
    tx_o      = 1'b0;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    case (st_q)
      S_IDLE: if (ev_i.start) begin
        st_d      = S_ADDR;
        cnt_clr_o = 1'b1;
      end
      S_ADDR: begin
        if (bus_evt && cnt_i != '0) begin
          st_d = S_ERR; si_d = 1'b1; status_d = CODE_BUSERR; sda_d = 1'b0;
        end else if (ev_i.start) begin
          cnt_clr_o = 1'b1;
        end else if (ev_i.stop) begin
          st_d = S_IDLE;
        end else if (ev_i.scl_rise && cnt_i != FULL) begin
          rx_o = 1'b1; cnt_inc_o = 1'b1;
        end else if (ev_i.scl_fall && cnt_i == FULL) begin
          if (addr_hit) begin
            st_d = S_AACK; sda_d = 1'b1;
          end else begin
            st_d = S_IDLE; arb_d = arb_lost_i;
          end
        end
      end
      S_AACK: begin
        if (bus_evt) begin
          st_d = S_ERR; si_d = 1'b1; status_d = CODE_BUSERR; sda_d = 1'b0;
        end else if (ev_i.scl_fall) begin
          st_d     = S_HOLD;
          si_d     = 1'b1;
          status_d = arb_q ? CODE_ARB_RD : CODE_ADDR_RD;
          arb_d    = arb_lost_i;
          sda_d    = 1'b0;
        end
      end
      S_TX: begin
        if (bus_evt) begin
          st_d = S_ERR; si_d = 1'b1; status_d = CODE_BUSERR; sda_d = 1'b0;
        end else if (ev_i.scl_fall) begin
          cnt_inc_o = 1'b1;
          if (cnt_i == LAST) begin
            st_d = S_TACK; sda_d = 1'b0;
          end else begin
            tx_o = 1'b1; sda_d = ~sr_i[W-2];
          end
        end
      end
      S_TACK: begin
        if (bus_evt) begin
          st_d = S_ERR; si_d = 1'b1; status_d = CODE_BUSERR; sda_d = 1'b0;
        end else if (ev_i.scl_rise) begin
          ack_d = ~ev_i.sda_lvl;
        end else if (ev_i.scl_fall) begin
          st_d = S_HOLD;
          si_d = 1'b1;
          if (!ack_q)     status_d = CODE_DATA_NAK;
          else if (last_q) status_d = CODE_LAST_ACK;
          else             status_d = CODE_DATA_ACK;
        end
      end
      S_HOLD: if (clr_req) begin
        si_d     = 1'b0;
        status_d = CODE_NONE;
        if (status_o inside {CODE_ADDR_RD, CODE_ARB_RD, CODE_DATA_ACK}) begin
          st_d      = S_TX;
          load_o    = 1'b1;
          cnt_clr_o = 1'b1;
          sda_d     = ~tx_msb_i;
          last_d    = ~aa_i;
        end else begin
          st_d = S_IDLE;
        end
      end
      S_ERR: if (clr_req && host_sto_i) begin
        st_d = S_IDLE; si_d = 1'b0; status_d = CODE_NONE; sda_d = 1'b0;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      si_o     <= 1'b0;
      status_o <= CODE_NONE;
      sda_oe_o <= 1'b0;
      last_q   <= 1'b0;
      ack_q    <= 1'b0;
      arb_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      si_o     <= si_d;
      status_o <= status_d;
      sda_oe_o <= sda_d;
      last_q   <= last_d;
      ack_q    <= ack_d;
      arb_q    <= arb_d;
    end
  end

  // R2: idle code whenever the flag is down
  a_r2_code_when_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !si_o |-> status_o == CODE_NONE);

  // R10: flag (and thus the SCL hold) persists until a clear write
  a_r10_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (si_o && !clr_req) |=> si_o);

  // R6: SDA drive changes only while SCL is low, bus-error entry aside
  a_r6_sda_moves_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> (!ev_i.scl_lvl || st_q == S_ERR));

  // R11: bus-error entry needs a START or STOP
  a_r11_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_ERR && !$stable(st_q)) |-> $past(bus_evt));

  // R12: bus-error state is left only with the stop request
  a_r12_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_ERR && !(clr_req && host_sto_i)) |=> (st_q == S_ERR && si_o));

  // R4: acknowledge only for a matching read address
  a_r4_ack_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_AACK && $rose(sda_oe_o)) |-> $past(addr_hit));

endmodule

// File: rtl/i2c_tgt_tx_status.sv
module i2c_tgt_tx_status
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [DATA_W-2:0] own_addr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              aa_i,
  input  logic              host_wr_i,
  input  logic              host_si_clr_i,
  input  logic              host_sto_i,
  input  logic              arb_lost_i,
  output logic              si_o,
  output logic [7:0]        status_o
);

  localparam int CW = $clog2(DATA_W + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  bus_ev_t           ev;
  logic [DATA_W-1:0] sr;
  logic [CW-1:0]     cnt;
  logic              load, rx, tx, cnt_clr, cnt_inc;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  i2c_tgt_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .ev_o   (ev)
  );

  i2c_tgt_byte_shift #(.W(DATA_W), .CW(CW)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .load_i     (load),
    .load_val_i (tx_data_i),
    .rx_i       (rx),
    .tx_i       (tx),
    .bit_i      (ev.sda_lvl),
    .cnt_clr_i  (cnt_clr),
    .cnt_inc_i  (cnt_inc),
    .sr_o       (sr),
    .cnt_o      (cnt)
  );

  i2c_tgt_ctrl #(.W(DATA_W), .CW(CW)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_n_int),
    .ev_i          (ev),
    .sr_i          (sr),
    .cnt_i         (cnt),
    .own_addr_i    (own_addr_i),
    .tx_msb_i      (tx_data_i[DATA_W-1]),
    .aa_i          (aa_i),
    .host_wr_i     (host_wr_i),
    .host_si_clr_i (host_si_clr_i),
    .host_sto_i    (host_sto_i),
    .arb_lost_i    (arb_lost_i),
    .load_o        (load),
    .rx_o          (rx),
    .tx_o          (tx),
    .cnt_clr_o     (cnt_clr),
    .cnt_inc_o     (cnt_inc),
    .si_o          (si_o),
    .status_o      (status_o),
    .sda_oe_o      (sda_oe_o)
  );

  // stretching follows the interrupt flag
  assign scl_oe_o = si_o;

endmodule

// File: tb/test_i2c_tgt_tx_status.sv
`timescale 1ns/1ps
module test_i2c_tgt_tx_status;

  localparam int H = 8;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_w, sda_w, scl_oe, sda_oe;
  logic [7:0] tx_data = 8'h00;
  logic aa = 1'b1, hwr = 1'b0, hclr = 1'b0, hsto = 1'b0, arb = 1'b0;
  logic si;
  logic [7:0] status;

  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #2 clk = ~clk;

  assign scl_w = ~(m_scl_low | scl_oe);
  assign sda_w = ~(m_sda_low | sda_oe);

  i2c_tgt_tx_status i_i2c_tgt_tx_status (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_w), .sda_i(sda_w),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .own_addr_i(OWN),
    .tx_data_i(tx_data), .aa_i(aa), .host_wr_i(hwr), .host_si_clr_i(hclr),
    .host_sto_i(hsto), .arb_lost_i(arb), .si_o(si), .status_o(status)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model: queue of expected status codes, compared each clock
  logic si_prev = 1'b0, oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!si && status != 8'hF8) check(0, "R2", "status with flag low", status, 8'hF8);
      if (si && !scl_oe) check(0, "R10", "SCL not held", scl_oe, 1);
      if (scl_w && sda_oe != oe_prev && !(si && status == 8'h00))
        check(0, "R6", "SDA drive moved with SCL high", sda_oe, oe_prev);
      if (si && !si_prev) begin
        if (exp_q.size() == 0) check(0, "R4", "unexpected flag", status, 8'hF8);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(status == e, t, "status on flag", status, e);
        end
      end
    end
    si_prev <= si;
    oe_prev <= sda_oe;
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_w) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b1; wclk(H);
    m_scl_low = 1'b1; wclk(H);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; wclk(H);
    m_scl_low = 1'b0; wait_scl_high(); wclk(H);
    m_sda_low = 1'b0; wclk(H);
  endtask

  task automatic clock_bit(input bit b, output bit s);
    m_sda_low = ~b; wclk(H);
    m_scl_low = 1'b0; wait_scl_high(); wclk(H);
    s = sda_w;
    m_scl_low = 1'b1; wclk(H);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ackbit);
    bit s;
    for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
    clock_bit(1'b1, ackbit);
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] v);
    bit s;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, s);
      v = {v[6:0], s};
    end
    clock_bit(~give_ack, s);
  endtask

  task automatic expect_code(input logic [7:0] c, input string t);
    exp_q.push_back(c); tag_q.push_back(t);
  endtask

  task automatic wait_flag(input string t);
    int g = 0;
    while (!si && g < 60) begin @(negedge clk); g++; end
    check(si == 1'b1, t, "flag raised", si, 1);
  endtask

  task automatic host_clear(input bit a, input logic [7:0] d, input bit sto);
    tx_data = d; aa = a; hwr = 1'b1; hclr = 1'b1; hsto = sto;
    @(negedge clk);
    hwr = 1'b0; hclr = 1'b0; hsto = 1'b0;
    wclk(2);
  endtask

  initial begin
    logic [7:0] v;
    bit ab;
    wclk(5);
    rst_n = 1'b1;
    wclk(4);
    // R1 reset state
    check(si == 0 && status == 8'hF8, "R1", "flag/status after reset", {si, status}, 9'h0F8);
    check(!scl_oe && !sda_oe, "R1", "lines released after reset", {scl_oe, sda_oe}, 0);

    // read transfer: three bytes, last chosen by AA=0
    bus_start();
    expect_code(8'hA8, "R3");
    send_byte({OWN, 1'b1}, ab);
    check(ab == 1'b0, "R3", "address acknowledged", ab, 0);
    wait_flag("R3");
    m_scl_low = 1'b0; wclk(20);
    check(scl_w == 1'b0, "R10", "SCL stretched", scl_w, 0);
    m_scl_low = 1'b1;
    host_clear(1'b1, 8'hA5, 1'b0);
    check(!scl_oe, "R10", "SCL released by clear", scl_oe, 0);
    expect_code(8'hB8, "R7");
    read_byte(1'b1, v);
    check(v == 8'hA5, "R6", "first byte", v, 8'hA5);
    wait_flag("R7");
    host_clear(1'b0, 8'h3C, 1'b0);
    expect_code(8'hC8, "R9");
    read_byte(1'b1, v);
    check(v == 8'h3C, "R6", "second byte", v, 8'h3C);
    wait_flag("R9");
    host_clear(1'b1, 8'h00, 1'b0);
    read_byte(1'b1, v);
    check(v == 8'hFF, "R9", "all ones after last byte", v, 8'hFF);
    check(si == 1'b0, "R9", "no flag after last byte", si, 0);
    bus_stop();

    // write direction and foreign address
    bus_start();
    send_byte({OWN, 1'b0}, ab);
    check(ab == 1'b1, "R4", "write address not acknowledged", ab, 1);
    wclk(20);
    check(si == 1'b0, "R4", "no flag on write address", si, 0);
    bus_stop();
    bus_start();
    send_byte({OWN ^ 7'h01, 1'b1}, ab);
    check(ab == 1'b1, "R4", "foreign address not acknowledged", ab, 1);
    wclk(20);
    check(si == 1'b0, "R4", "no flag on foreign address", si, 0);
    bus_stop();

    // arbitration-lost entry, then not-acknowledge
    arb = 1'b1; @(negedge clk); arb = 1'b0;
    bus_start();
    expect_code(8'hB0, "R5");
    send_byte({OWN, 1'b1}, ab);
    check(ab == 1'b0, "R5", "address acknowledged", ab, 0);
    wait_flag("R5");
    host_clear(1'b1, 8'h96, 1'b0);
    expect_code(8'hC0, "R8");
    read_byte(1'b0, v);
    check(v == 8'h96, "R6", "byte before not-acknowledge", v, 8'h96);
    wait_flag("R8");
    host_clear(1'b1, 8'h00, 1'b0);
    read_byte(1'b1, v);
    check(v == 8'hFF, "R8", "all ones when not addressed", v, 8'hFF);
    check(si == 1'b0, "R8", "no flag when not addressed", si, 0);
    bus_stop();

    // START inside a data byte
    bus_start();
    expect_code(8'hA8, "R3");
    send_byte({OWN, 1'b1}, ab);
    wait_flag("R3");
    host_clear(1'b1, 8'hFF, 1'b0);
    for (int i = 0; i < 3; i++) clock_bit(1'b1, ab);
    expect_code(8'h00, "R11");
    m_scl_low = 1'b0; wait_scl_high(); wclk(H);
    m_sda_low = 1'b1; wclk(H);
    wait_flag("R11");
    m_sda_low = 1'b0;
    host_clear(1'b1, 8'h00, 1'b0);
    wclk(10);
    check(si == 1'b1 && status == 8'h00, "R12", "clear without stop ignored", {si, status}, 9'h100);
    host_clear(1'b1, 8'h00, 1'b1);
    wclk(10);
    check(si == 1'b0 && status == 8'hF8, "R12", "stop-clear leaves error", {si, status}, 9'h0F8);
    check(!scl_oe && !sda_oe && sda_w && scl_w, "R12", "lines released, no STOP driven",
          {scl_oe, sda_oe}, 0);

    // START during the acknowledge bit after a not-acknowledge
    bus_start();
    expect_code(8'hA8, "R3");
    send_byte({OWN, 1'b1}, ab);
    wait_flag("R3");
    host_clear(1'b1, 8'h00, 1'b0);
    for (int i = 0; i < 8; i++) clock_bit(1'b1, ab);
    expect_code(8'h00, "R11");
    m_sda_low = 1'b0; wclk(H);
    m_scl_low = 1'b0; wait_scl_high(); wclk(H);
    m_sda_low = 1'b1; wclk(H);
    wait_flag("R11");
    check(status == 8'h00, "R11", "error wins over not-acknowledge", status, 8'h00);
    host_clear(1'b1, 8'h00, 1'b1);
    wclk(10);
    check(si == 1'b0 && !scl_oe, "R12", "recovered after ack-bit error", {si, scl_oe}, 0);
    m_sda_low = 1'b0; wclk(H);
    check(si == 1'b0, "R12", "idle STOP after recovery", si, 0);

    check(exp_q.size() == 0, "R2", "all expected codes seen", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(negedge clk); cyc++; end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule